// File: doc/BRIEF.md
# Quiescent Current Signature Extractor

This block turns the one-bit outputs of several built-in supply-current sensors into a single test verdict for a device under test. Each sensor watches one partition of the device. A sensor bit is 1 when that partition's measured quiescent current is above its current limit, and 0 when the current is at or below the limit. The block ORs all sensor bits into one detection line.

After each vector strobe, the block waits a programmable settle delay so that switching transients can die out. It then samples the detection line exactly once. It counts the vectors whose sample was high, and this count is the signature.

A programmable number of vectors makes up one run. The device is rejected when the signature reaches a programmable signature threshold. A single flagged vector is therefore not enough to reject the device. A run normally applies more vectors than the threshold value. A start/clear pulse prepares the block for the next run.

Top module: `leak_sig_extractor`

## Requirements
- R1: After reset, `signature`, `reject` and `run_done` are all 0.
- R2: A vector is counted when at least one bit of `sense_i` is 1 at its sampling edge. Any single bit or any combination of bits counts.
- R3: A vector adds exactly one to the signature, however many sensor bits are 1 at its sampling edge.
- R4: A strobe seen at clock edge E0 samples `sense_i` only at edge E0+`settle_cycles`+1. Sensor values during the earlier settle edges have no effect.
- R5: A strobe that arrives while a vector is still settling is ignored. It neither restarts the delay nor adds a sample.
- R6: The signature saturates at its maximum value, 2^CNT_W-1, and never wraps.
- R7: `reject` rises in the cycle after the sample that brings the signature to a value greater than or equal to `sig_thresh`. This can happen before the run is complete. Once high, `reject` stays high until a clear.
- R8: `run_done` rises after the sample of the `vec_total`-th vector (`vec_total` must be at least 1). While `run_done` is high, strobes are ignored, and `signature` and `reject` hold their values.
- R9: A `run_clr` pulse zeroes the signature and the vector count, lowers `reject` and `run_done`, and abandons any settling vector. It takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_clr | input | 1 | Start/clear pulse for a new run |
| vec_stb | input | 1 | One-cycle pulse when a test vector is applied |
| sense_i | input | N_SENSE | Over-limit bits, one per partition sensor |
| settle_cycles | input | SETTLE_W | Settle delay in clock cycles, counted after the strobe |
| sig_thresh | input | CNT_W | Signature value at or above which the device is rejected |
| vec_total | input | VEC_W | Number of vectors in one run |
| signature | output | CNT_W | Running count of flagged vectors |
| run_done | output | 1 | All vectors of the run have been sampled |
| reject | output | 1 | Device judged faulty |

## Verification
Directed patterns do four things:
- A lone sensor bit, several bits and all bits together separate the OR merge from a per-sensor count.
- Inverting the sensor values just before the sampling edge shows whether the sample is taken at settle expiry or earlier.
- A second strobe inside the settle window exposes a timer that restarts or double-counts.
- Strobes issued after the run completes show whether the finished state is really frozen.

A long all-ones run with no settle delay drives the counter into saturation and separates saturation from wrap-around. Randomly sparse sensor patterns with random thresholds, run lengths and delays compare early rejection, the end-of-run flag and the final verdict against a bench model.

// File: rtl/lse_pkg.sv
package lse_pkg;
   typedef enum logic {
      TMR_IDLE   = 1'b0,
      TMR_SETTLE = 1'b1
   } tmr_state_e;
endpackage

// File: rtl/lse_sense_merge.sv
module lse_sense_merge #(
   parameter int N_SENSE = 8
) (
   input  logic [N_SENSE-1:0] sense_i,
   output logic               hit_o
);
   generate
      if (N_SENSE < 1) begin : g_bad_width
         $error("lse_sense_merge: N_SENSE must be at least 1");
      end
      if (N_SENSE == 1) begin : g_single
         assign hit_o = sense_i[0];
      end else begin : g_tree
         assign hit_o = |sense_i;
      end
   endgenerate
endmodule

// File: rtl/lse_settle_timer.sv
module lse_settle_timer
   import lse_pkg::*;
#(
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                stb_i,
   input  logic                arm_en_i,
   input  logic [SETTLE_W-1:0] delay_i,
   output logic                sample_o
);
   tmr_state_e          state_q;
   logic [SETTLE_W-1:0] cnt_q;

   generate
      if (SETTLE_W < 1) begin : g_bad_width
         $error("lse_settle_timer: SETTLE_W must be at least 1");
      end
   endgenerate

   assign sample_o = (state_q == TMR_SETTLE) && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TMR_IDLE;
         cnt_q   <= '0;
      end else if (clr_i) begin
         state_q <= TMR_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            TMR_IDLE: begin
               if (stb_i && arm_en_i) begin
                  state_q <= TMR_SETTLE;
                  cnt_q   <= delay_i;
               end
            end
            default: begin
               if (cnt_q == '0) state_q <= TMR_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
         endcase
      end
   end

   // R4
   one_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |=> !sample_o);

   // R5
   settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TMR_SETTLE && cnt_q != '0 && !clr_i)
      |=> (state_q == TMR_SETTLE && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lse_sig_counter.sv
module lse_sig_counter #(
   parameter int CNT_W = 8,
   parameter int VEC_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             sample_i,
   input  logic             hit_i,
   input  logic [CNT_W-1:0] thr_i,
   input  logic [VEC_W-1:0] total_i,
   output logic [CNT_W-1:0] sig_o,
   output logic             reject_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] SIG_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] sig_q, sig_nxt;
   logic [VEC_W-1:0] vcnt_q, vcnt_nxt;
   logic             rej_q, done_q;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("lse_sig_counter: CNT_W must be at least 2");
      end
      if (VEC_W < 1) begin : g_bad_vec
         $error("lse_sig_counter: VEC_W must be at least 1");
      end
   endgenerate

   always_comb begin
      sig_nxt  = (hit_i && sig_q != SIG_MAX) ? sig_q + 1'b1 : sig_q;
      vcnt_nxt = vcnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_q  <= '0;
         vcnt_q <= '0;
         rej_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (clr_i) begin
         sig_q  <= '0;
         vcnt_q <= '0;
         rej_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (sample_i && !done_q) begin
         sig_q  <= sig_nxt;
         vcnt_q <= vcnt_nxt;
         if (sig_nxt >= thr_i)    rej_q  <= 1'b1;
         if (vcnt_nxt == total_i) done_q <= 1'b1;
      end
   end

   assign sig_o    = sig_q;
   assign reject_o = rej_q;
   assign done_o   = done_q;

   // R3
   unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (sig_q == $past(sig_q) || sig_q == $past(sig_q) + 1'b1));

   // R6
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_q == SIG_MAX && !clr_i) |=> sig_q == SIG_MAX);

   // R7
   reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rej_q && !clr_i) |=> rej_q);

   // R8
   done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !clr_i) |=> (done_q && $stable(sig_q) && $stable(rej_q)));

   // R9
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (sig_q == '0 && !rej_q && !done_q));
endmodule

// File: rtl/leak_sig_extractor.sv
module leak_sig_extractor #(
   parameter int N_SENSE  = 8,
   parameter int CNT_W    = 8,
   parameter int SETTLE_W = 8,
   parameter int VEC_W    = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run_clr,
   input  logic                vec_stb,
   input  logic [N_SENSE-1:0]  sense_i,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic [CNT_W-1:0]    sig_thresh,
   input  logic [VEC_W-1:0]    vec_total,
   output logic [CNT_W-1:0]    signature,
   output logic                run_done,
   output logic                reject
);
   logic hit;
   logic sample;

   lse_sense_merge #(.N_SENSE(N_SENSE)) u_merge (
      .sense_i (sense_i),
      .hit_o   (hit)
   );

   lse_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (run_clr),
      .stb_i    (vec_stb),
      .arm_en_i (!run_done),
      .delay_i  (settle_cycles),
      .sample_o (sample)
   );

   lse_sig_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (run_clr),
      .sample_i (sample),
      .hit_i    (hit),
      .thr_i    (sig_thresh),
      .total_i  (vec_total),
      .sig_o    (signature),
      .reject_o (reject),
      .done_o   (run_done)
   );

   // R2
   quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && sense_i == '0 && !run_clr) |=> $stable(signature));
endmodule

// File: tb/tb_leak_sig_extractor.sv
`timescale 1ns/1ps
module tb_leak_sig_extractor;
   localparam int NS  = 8;
   localparam int CW  = 8;
   localparam int SW  = 8;
   localparam int VW  = 10;
   localparam int MAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_clr = 1'b0;
   logic          vec_stb = 1'b0;
   logic [NS-1:0] sense_i = '0;
   logic [SW-1:0] settle_cycles = '0;
   logic [CW-1:0] sig_thresh = '0;
   logic [VW-1:0] vec_total = '0;
   logic [CW-1:0] signature;
   logic          run_done, reject;

   int n_chk = 0, n_fail = 0;
   int m_sig = 0, m_vec = 0;
   bit m_rej = 0, m_done = 0;
   bit finished = 0;

   leak_sig_extractor #(.N_SENSE(NS), .CNT_W(CW), .SETTLE_W(SW), .VEC_W(VW)) dut (
      .clk(clk), .rst_n(rst_n), .run_clr(run_clr), .vec_stb(vec_stb),
      .sense_i(sense_i), .settle_cycles(settle_cycles), .sig_thresh(sig_thresh),
      .vec_total(vec_total), .signature(signature), .run_done(run_done),
      .reject(reject)
   );

   always #2.5 clk = ~clk;

   function automatic int model_sig(input int cur, input logic [NS-1:0] pat);
      return (pat != '0 && cur < MAX) ? cur + 1 : cur;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_all(input string sreq, input string rreq, input string dreq);
      chk(sreq, int'(signature), m_sig);
      chk(rreq, int'(reject), int'(m_rej));
      chk(dreq, int'(run_done), int'(m_done));
   endtask

   task automatic set_run(input int d, input int thr, input int tot);
      @(negedge clk);
      settle_cycles = SW'(d);
      sig_thresh    = CW'(thr);
      vec_total     = VW'(tot);
   endtask

   task automatic do_clear();
      @(negedge clk);
      run_clr = 1'b1;
      vec_stb = 1'b1;
      sense_i = '1;
      @(posedge clk);
      @(negedge clk);
      run_clr = 1'b0;
      vec_stb = 1'b0;
      sense_i = '0;
      m_sig = 0; m_vec = 0; m_rej = 0; m_done = 0;
      // R9: the strobe that came with the clear must not start a vector
      repeat (int'(settle_cycles) + 3) @(posedge clk);
      @(negedge clk);
      check_all("R9", "R9", "R9");
   endtask

   // glitch: sensors carry ~pat during settle, pat only at the sampling edge
   // restrobe: a second strobe inside the settle window
   task automatic run_vec(input logic [NS-1:0] pat, input bit glitch, input bit restrobe,
                          input string sreq, input string rreq, input string dreq);
      int d;
      d = int'(settle_cycles);
      @(negedge clk);
      sense_i = glitch ? ~pat : pat;
      vec_stb = 1'b1;
      @(posedge clk);
      @(negedge clk);
      vec_stb = 1'b0;
      for (int i = 0; i < d; i++) begin
         if (restrobe && i == 0) vec_stb = 1'b1;
         @(posedge clk);
         @(negedge clk);
         vec_stb = 1'b0;
      end
      sense_i = pat;
      @(posedge clk);
      @(negedge clk);
      sense_i = glitch ? ~pat : '0;
      if (!m_done) begin
         m_vec++;
         m_sig = model_sig(m_sig, pat);
         if (m_sig >= int'(sig_thresh)) m_rej = 1;
         if (m_vec == int'(vec_total)) m_done = 1;
      end
      check_all(sreq, rreq, dreq);
      // R4: a sample taken late would show up here
      @(posedge clk);
      @(negedge clk);
      sense_i = '0;
      chk(sreq, int'(signature), m_sig);
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_up();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1
      check_all("R1", "R1", "R1");
      rst_n = 1'b1;

      // directed run: threshold 3 of 6 vectors
      set_run(3, 3, 6);
      run_vec(8'h00, 0, 0, "R2", "R7", "R8");
      run_vec(8'h10, 0, 0, "R2", "R7", "R8");
      run_vec(8'hFF, 0, 0, "R3", "R7", "R8");
      run_vec(8'h81, 0, 0, "R3", "R7", "R8");   // signature reaches 3: early reject
      chk("R7", int'(reject), 1);
      chk("R8", int'(run_done), 0);
      run_vec(8'h00, 0, 0, "R2", "R7", "R8");
      run_vec(8'h01, 0, 0, "R2", "R7", "R8");   // sixth vector: run complete
      chk("R8", int'(run_done), 1);
      run_vec(8'hFF, 0, 0, "R8", "R8", "R8");   // ignored after completion
      run_vec(8'h0F, 0, 0, "R8", "R8", "R8");
      do_clear();

      // R4: sample timing, with glitches either way
      set_run(4, 10, 20);
      run_vec(8'h00, 1, 0, "R4", "R7", "R8");
      run_vec(8'h00, 1, 0, "R4", "R7", "R8");
      run_vec(8'h20, 1, 0, "R4", "R7", "R8");
      set_run(0, 10, 20);
      run_vec(8'h00, 1, 0, "R4", "R7", "R8");
      run_vec(8'h02, 1, 0, "R4", "R7", "R8");
      // R5: restrobe inside the settle window
      set_run(5, 10, 20);
      run_vec(8'h40, 0, 1, "R5", "R7", "R8");
      run_vec(8'h00, 0, 1, "R5", "R7", "R8");
      chk("R5", int'(signature), 3);
      do_clear();

      // R7: below threshold at end of run gives no reject
      set_run(1, 5, 8);
      for (int i = 0; i < 8; i++)
         run_vec((i % 2 == 0) ? NS'(1 << (i % NS)) : '0, 0, 0, "R2", "R7", "R8");
      chk("R7", int'(reject), 0);
      chk("R8", int'(run_done), 1);
      do_clear();

      // R6: saturation
      set_run(0, MAX, MAX + 20);
      for (int i = 0; i < MAX + 10; i++)
         run_vec('1, 0, 0, "R6", "R7", "R8");
      chk("R6", int'(signature), MAX);
      chk("R7", int'(reject), 1);
      do_clear();

      // random runs
      for (int r = 0; r < 6; r++) begin
         int d, thr, tot;
         d   = int'($urandom % 6);
         thr = 1 + int'($urandom % 12);
         tot = thr + 1 + int'($urandom % 30);
         set_run(d, thr, tot);
         for (int v = 0; v < tot + 2; v++) begin
            logic [NS-1:0] pat;
            pat = ($urandom % 3 == 0) ? NS'($urandom) : '0;
            run_vec(pat, bit'($urandom % 4 == 0), bit'(d > 0 && $urandom % 5 == 0),
                    "R2", "R7", "R8");
         end
         chk("R8", int'(run_done), 1);
         do_clear();
      end

      finish_up();
   end
endmodule